// File: doc/BRIEF.md
# Address Arithmetic Unit with Multi-Wrap Modulo

This block is the arithmetic half of a DSP address generation path. It holds sixteen 32-bit address registers, four offset registers and one modifier register for each of the lower eight address registers. Each accepted operation reads a destination address register and a source operand, then writes the result back in the same clock. The source is another address register, an offset register or an immediate. The operations are add, add with the source shifted left by one or two bits, decrement, decrement-and-test, three shifts and three compares. Compares and decrement-and-test report their outcome on a single registered true flag.

For address registers 0 to 7, adds and plain decrements pass through modulo logic. When the modifier holds 2^k-1, only the low k bits of the register take the linear result, and the upper bits keep their old value. The address therefore wraps inside a 2^k-aligned window, and any overshoot folds back into it. An all-ones modifier gives plain linear arithmetic. Registers 8 to 15 never wrap. A separate register-write port loads any register, and a combinational read port shows any register, so a decoder or a debugger can set up state and watch the results.

Top module: `addr_arith_unit`

## Requirements
- R1: While rst_n is low at a clock edge, every address and offset register is cleared to 0, every modifier register is set to 0xFFFFFFFF and the true flag is cleared to 0.
- R2: A write-port strobe loads wr_data into the register selected by wr_kind (0 = address, 1 = offset, 2 = modifier, 3 = none) and wr_idx at the clock edge. Offset registers use wr_idx[1:0] and modifiers use wr_idx[2:0]. rd_kind/rd_idx select with the same encoding and show the register combinationally, and kind 3 reads 0. If an operation and the write port target the same register in the same cycle, the written value is kept.
- R3: The add opcodes compute dst + src (op 1), dst + (src << 1) (op 2) and dst + (src << 2) (op 3), modulo 2^32 when the modifier is all ones. src is address register src_idx for src_kind 0, offset register src_idx[1:0] for src_kind 1, and op_imm for src_kind 2 or 3.
- R4: For destinations 0 to 7, add and decrement results equal (old & ~M) | (linear & M), where M is that register's modifier. With M = 2^k-1 the result wraps from the top of the window to its base and from its base to its top, and bits above bit k-1 never change.
- R5: Destinations 8 to 15 always receive the plain linear result of add and decrement, whatever any modifier holds.
- R6: Decrement (op 4) subtracts one under the modifier rule. Decrement-and-test (op 5) always subtracts one linearly and sets the true flag to 1 exactly when the new value is zero.
- R7: Shift-left-by-one (op 6), shift-left-by-two (op 7) and arithmetic shift-right-by-one (op 8) act on all 32 bits of the destination and ignore its modifier.
- R8: Compare-equal (op 9), signed greater-than (op 10, dst > src) and unsigned higher (op 11, dst > src) load the true flag from the result and leave every register unchanged.
- R9: The true flag changes only on compares and decrement-and-test. Every other opcode, including no-op (op 0), leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Perform op_code this cycle |
| op_code | input | 4 | Decoded operation |
| op_dst | input | 4 | Destination address register index |
| src_kind | input | 2 | Source type: 0 address, 1 offset, 2/3 immediate |
| src_idx | input | 4 | Source register index |
| op_imm | input | 32 | Immediate operand |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Written register type |
| wr_idx | input | 4 | Written register index |
| wr_data | input | 32 | Written value |
| rd_kind | input | 2 | Read register type |
| rd_idx | input | 4 | Read register index |
| rd_data | output | 32 | Selected register value |
| t_flag | output | 1 | True flag |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, sixteen address registers of which the lower eight wrap, and four offset registers. At full width the bench can reach a 2^31 modulus, where the merge keeps only the top bit. It can also reach operands with bit 31 set, where the signed and unsigned compares give opposite answers. With eight wrapping and eight linear registers in one file, the bench can run the same operation on both halves and see the boundary at index 8. A random run, checked against a model held in the bench, mixes modifiers of every power-of-two size across all opcodes.

// File: rtl/aau_pkg.sv
// Package: shared encodings of the address arithmetic unit.
// Assumes: opcode values are fixed by the decoder upstream.
package aau_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_ADDS1 = 4'd2,
        OP_ADDS2 = 4'd3,
        OP_DEC   = 4'd4,
        OP_DECT  = 4'd5,
        OP_SHL1  = 4'd6,
        OP_SHL2  = 4'd7,
        OP_SHR1  = 4'd8,
        OP_CEQ   = 4'd9,
        OP_CGT   = 4'd10,
        OP_CHI   = 4'd11
    } aau_op_e;

    typedef enum logic [1:0] {
        RK_ADDR = 2'd0,
        RK_OFFS = 2'd1,
        RK_MODF = 2'd2,
        RK_NONE = 2'd3
    } aau_kind_e;

endpackage

// File: rtl/aau_exec.sv
// Module: aau_exec
// Computes the linear result and the true-flag outcome of one operation.
// It also says whether the result is written back and whether the modulo
// merge may shape it. Assumes the caller gates all outputs with op_valid.
module aau_exec
    import aau_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  aau_op_e           op,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    output logic [DATA_W-1:0] lin_res,
    output logic              res_wr,
    output logic              res_mod,
    output logic              t_wr,
    output logic              t_val
);

    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    // Select the operation result and its write-back and flag controls.
    always_comb begin
        lin_res = dst_val;
        res_wr  = 1'b0;
        res_mod = 1'b0;
        t_wr    = 1'b0;
        t_val   = 1'b0;
        case (op)
            OP_ADD: begin
                lin_res = dst_val + src_val;
                res_wr  = 1'b1;
                res_mod = 1'b1;
            end
            OP_ADDS1: begin
                lin_res = dst_val + {src_val[DATA_W-2:0], 1'b0};
                res_wr  = 1'b1;
                res_mod = 1'b1;
            end
            OP_ADDS2: begin
                lin_res = dst_val + {src_val[DATA_W-3:0], 2'b00};
                res_wr  = 1'b1;
                res_mod = 1'b1;
            end
            OP_DEC: begin
                lin_res = dst_val - ONE;
                res_wr  = 1'b1;
                res_mod = 1'b1;
            end
            OP_DECT: begin
                lin_res = dst_val - ONE;
                res_wr  = 1'b1;
                t_wr    = 1'b1;
                t_val   = (lin_res == '0);
            end
            OP_SHL1: begin
                lin_res = {dst_val[DATA_W-2:0], 1'b0};
                res_wr  = 1'b1;
            end
            OP_SHL2: begin
                lin_res = {dst_val[DATA_W-3:0], 2'b00};
                res_wr  = 1'b1;
            end
            OP_SHR1: begin
                lin_res = {dst_val[DATA_W-1], dst_val[DATA_W-1:1]};
                res_wr  = 1'b1;
            end
            OP_CEQ: begin
                t_wr  = 1'b1;
                t_val = (dst_val == src_val);
            end
            OP_CGT: begin
                t_wr  = 1'b1;
                t_val = ($signed(dst_val) > $signed(src_val));
            end
            OP_CHI: begin
                t_wr  = 1'b1;
                t_val = (dst_val > src_val);
            end
            default: begin
                lin_res = dst_val;
            end
        endcase
    end

endmodule

// File: rtl/aau_modwrap.sv
// Module: aau_modwrap
// Merges a linear result into the old register value under a mask.
// Bits inside the mask come from the linear result and bits outside it
// keep their old value, so no carry or borrow leaves the window.
// Assumes the mask is 2^k-1, or all ones for linear behaviour.
module aau_modwrap #(
    parameter int DATA_W = 32
) (
    input  logic              apply,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] lin_val,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] res_val
);

    // Merge the masked field, or pass the linear value straight through.
    always_comb begin
        if (apply) res_val = (old_val & ~mask) | (lin_val & mask);
        else       res_val = lin_val;
    end

endmodule

// File: rtl/aau_regfile.sv
// Module: aau_regfile
// Holds the address, offset and modifier registers. Only the lowest
// NUM_WRAP address registers get a modulo merge stage; the rest take the
// linear result. The write port has priority over operation write-back.
// Assumes offset and modifier counts are powers of two.
module aau_regfile
    import aau_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_AREG = 16,
    parameter int NUM_WRAP = 8,
    parameter int NUM_OREG = 4,
    localparam int AIDX_W  = $clog2(NUM_AREG),
    localparam int OIDX_W  = $clog2(NUM_OREG),
    localparam int MIDX_W  = $clog2(NUM_WRAP)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  aau_kind_e                          wr_kind,
    input  logic [AIDX_W-1:0]                  wr_idx,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               op_wr,
    input  logic                               op_mod,
    input  logic [AIDX_W-1:0]                  op_dst,
    input  logic [DATA_W-1:0]                  op_lin,
    output logic [NUM_AREG-1:0][DATA_W-1:0]    a_regs,
    output logic [NUM_OREG-1:0][DATA_W-1:0]    o_regs,
    output logic [NUM_WRAP-1:0][DATA_W-1:0]    m_regs
);

    for (genvar gi = 0; gi < NUM_AREG; gi++) begin : g_areg
        logic [DATA_W-1:0] next_val;

        if (gi < NUM_WRAP) begin : g_wrap
            aau_modwrap #(.DATA_W(DATA_W)) u_wrap (
                .apply   (op_mod),
                .old_val (a_regs[gi]),
                .lin_val (op_lin),
                .mask    (m_regs[gi]),
                .res_val (next_val)
            );
        end else begin : g_lin
            assign next_val = op_lin;
        end

        // Update one address register from the write port or an operation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_regs[gi] <= '0;
            end else if (wr_en && wr_kind == RK_ADDR && wr_idx == AIDX_W'(gi)) begin
                a_regs[gi] <= wr_data;
            end else if (op_wr && op_dst == AIDX_W'(gi)) begin
                a_regs[gi] <= next_val;
            end
        end
    end

    for (genvar go = 0; go < NUM_OREG; go++) begin : g_oreg
        // Load one offset register from the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                o_regs[go] <= '0;
            end else if (wr_en && wr_kind == RK_OFFS &&
                         wr_idx[OIDX_W-1:0] == OIDX_W'(go)) begin
                o_regs[go] <= wr_data;
            end
        end
    end

    for (genvar gm = 0; gm < NUM_WRAP; gm++) begin : g_mreg
        // Load one modifier register; reset leaves it in linear mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                m_regs[gm] <= '1;
            end else if (wr_en && wr_kind == RK_MODF &&
                         wr_idx[MIDX_W-1:0] == MIDX_W'(gm)) begin
                m_regs[gm] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/addr_arith_unit.sv
// Module: addr_arith_unit (top)
// Single-cycle address register arithmetic with per-register modulo wrap
// on the low address registers and a registered true flag.
// Assumes a decoded opcode arrives with op_valid; no internal pipelining.
module addr_arith_unit
    import aau_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_AREG = 16,
    parameter int NUM_WRAP = 8,
    parameter int NUM_OREG = 4,
    localparam int AIDX_W  = $clog2(NUM_AREG),
    localparam int OIDX_W  = $clog2(NUM_OREG),
    localparam int MIDX_W  = $clog2(NUM_WRAP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [AIDX_W-1:0] op_dst,
    input  logic [1:0]        src_kind,
    input  logic [AIDX_W-1:0] src_idx,
    input  logic [DATA_W-1:0] op_imm,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [AIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_kind,
    input  logic [AIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              t_flag
);

    logic [NUM_AREG-1:0][DATA_W-1:0] a_regs;
    logic [NUM_OREG-1:0][DATA_W-1:0] o_regs;
    logic [NUM_WRAP-1:0][DATA_W-1:0] m_regs;
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] lin_res;
    logic res_wr, res_mod, t_wr, t_val;

    // Pick the source operand from a register or the immediate.
    always_comb begin
        case (aau_kind_e'(src_kind))
            RK_ADDR: src_val = a_regs[src_idx];
            RK_OFFS: src_val = o_regs[src_idx[OIDX_W-1:0]];
            default: src_val = op_imm;
        endcase
    end

    aau_exec #(.DATA_W(DATA_W)) u_exec (
        .op      (aau_op_e'(op_code)),
        .dst_val (a_regs[op_dst]),
        .src_val (src_val),
        .lin_res (lin_res),
        .res_wr  (res_wr),
        .res_mod (res_mod),
        .t_wr    (t_wr),
        .t_val   (t_val)
    );

    aau_regfile #(
        .DATA_W   (DATA_W),
        .NUM_AREG (NUM_AREG),
        .NUM_WRAP (NUM_WRAP),
        .NUM_OREG (NUM_OREG)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_kind (aau_kind_e'(wr_kind)),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .op_wr   (op_valid && res_wr),
        .op_mod  (res_mod),
        .op_dst  (op_dst),
        .op_lin  (lin_res),
        .a_regs  (a_regs),
        .o_regs  (o_regs),
        .m_regs  (m_regs)
    );

    // Hold the true flag; only compares and decrement-test reload it.
    always_ff @(posedge clk) begin
        if (!rst_n)                t_flag <= 1'b0;
        else if (op_valid && t_wr) t_flag <= t_val;
    end

    // Drive the read port from the selected register.
    always_comb begin
        case (aau_kind_e'(rd_kind))
            RK_ADDR: rd_data = a_regs[rd_idx];
            RK_OFFS: rd_data = o_regs[rd_idx[OIDX_W-1:0]];
            RK_MODF: rd_data = m_regs[rd_idx[MIDX_W-1:0]];
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/aau_checker.sv
// Module: aau_checker
// Temporal properties of addr_arith_unit, attached with bind.
// Assumes the same parameters as the bound instance.
module aau_checker
    import aau_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_AREG = 16,
    parameter int NUM_WRAP = 8,
    parameter int NUM_OREG = 4,
    localparam int AIDX_W  = $clog2(NUM_AREG),
    localparam int MIDX_W  = $clog2(NUM_WRAP)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            op_valid,
    input logic [3:0]                      op_code,
    input logic [AIDX_W-1:0]               op_dst,
    input logic                            wr_en,
    input logic [NUM_AREG-1:0][DATA_W-1:0] a_regs,
    input logic [NUM_WRAP-1:0][DATA_W-1:0] m_regs,
    input logic [DATA_W-1:0]               src_val,
    input logic                            t_flag
);

    logic just_reset;
    logic is_cmp, is_dect, is_wrapop, is_shl1;

    // Mark the first cycle after a reset cycle.
    always_ff @(posedge clk) just_reset <= !rst_n;

    assign is_cmp    = op_code == OP_CEQ || op_code == OP_CGT || op_code == OP_CHI;
    assign is_dect   = op_code == OP_DECT;
    assign is_shl1   = op_code == OP_SHL1;
    assign is_wrapop = op_code == OP_ADD || op_code == OP_ADDS1 ||
                       op_code == OP_ADDS2 || op_code == OP_DEC;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        just_reset |-> (t_flag == 1'b0 && m_regs == '1 && a_regs == '0));

    a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_wrapop && !wr_en && op_dst < AIDX_W'(NUM_WRAP)) |=>
        (((a_regs[$past(op_dst)] ^ $past(a_regs[op_dst])) &
          ~$past(m_regs[op_dst[MIDX_W-1:0]])) == '0));

    a_r6_dect_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_dect && !wr_en) |=>
        (t_flag == (a_regs[$past(op_dst)] == '0)));

    a_r7_shl1_full: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_shl1 && !wr_en) |=>
        (a_regs[$past(op_dst)] == {$past(a_regs[op_dst][DATA_W-2:0]), 1'b0}));

    a_r8_cmp_regs_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_cmp && !wr_en) |=> $stable(a_regs));

    a_r8_signed_gt: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CGT) |=>
        (t_flag == $past($signed(a_regs[op_dst]) > $signed(src_val))));

    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && (is_cmp || is_dect)) |=> $stable(t_flag));

endmodule

bind addr_arith_unit aau_checker #(
    .DATA_W   (DATA_W),
    .NUM_AREG (NUM_AREG),
    .NUM_WRAP (NUM_WRAP),
    .NUM_OREG (NUM_OREG)
) u_aau_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_dst   (op_dst),
    .wr_en    (wr_en),
    .a_regs   (a_regs),
    .m_regs   (m_regs),
    .src_val  (src_val),
    .t_flag   (t_flag)
);

// File: tb/test_addr_arith_unit.sv
// Scoreboard bench: driver tasks update a model and queue expected
// read-port values; a monitor pops and compares each cycle.
module test_addr_arith_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [3:0]  op_dst = '0;
    logic [1:0]  src_kind = '0;
    logic [3:0]  src_idx = '0;
    logic [31:0] op_imm = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = '0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_kind = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        t_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] ma [16];
    logic [31:0] mo [4];
    logic [31:0] mm [8];
    logic        mt;

    string       q_tag [$];
    logic [31:0] q_val [$];
    logic        q_t   [$];

    addr_arith_unit i_addr_arith_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_dst(op_dst), .src_kind(src_kind), .src_idx(src_idx), .op_imm(op_imm),
        .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data), .t_flag(t_flag)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] model_read(input logic [1:0] k, input logic [3:0] i);
        case (k)
            2'd0:    return ma[i];
            2'd1:    return mo[i[1:0]];
            2'd2:    return mm[i[2:0]];
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] model_src(input logic [1:0] k, input logic [3:0] i,
                                              input logic [31:0] imm);
        case (k)
            2'd0:    return ma[i];
            2'd1:    return mo[i[1:0]];
            default: return imm;
        endcase
    endfunction

    // Apply one operation to the model (R3-R9).
    task automatic model_op(input logic [3:0] op, input logic [3:0] d, input logic [31:0] s);
        logic [31:0] old, lin;
        bit wr, wrap;
        old = ma[d];
        lin = old;
        wr = 1'b0;
        wrap = 1'b0;
        case (op)
            4'd1: begin lin = old + s;        wr = 1; wrap = 1; end
            4'd2: begin lin = old + (s << 1); wr = 1; wrap = 1; end
            4'd3: begin lin = old + (s << 2); wr = 1; wrap = 1; end
            4'd4: begin lin = old - 1;        wr = 1; wrap = 1; end
            4'd5: begin lin = old - 1;        wr = 1; mt = (lin == 0); end
            4'd6: begin lin = old << 1;       wr = 1; end
            4'd7: begin lin = old << 2;       wr = 1; end
            4'd8: begin lin = $unsigned($signed(old) >>> 1); wr = 1; end
            4'd9:  mt = (old == s);
            4'd10: mt = ($signed(old) > $signed(s));
            4'd11: mt = (old > s);
            default: ;
        endcase
        if (wr) begin
            if (wrap && d < 8) ma[d] = (old & ~mm[d[2:0]]) | (lin & mm[d[2:0]]);
            else               ma[d] = lin;
        end
    endtask

    // Select a register after the next edge and queue its expected value.
    task automatic expect_read(input logic [1:0] k, input logic [3:0] i, input string tag);
        @(posedge clk);
        #2;
        rd_kind = k;
        rd_idx  = i;
        q_tag.push_back(tag);
        q_val.push_back(model_read(k, i));
        q_t.push_back(mt);
    endtask

    task automatic do_write(input logic [1:0] k, input logic [3:0] i,
                            input logic [31:0] v, input string tag);
        @(negedge clk);
        wr_en = 1; wr_kind = k; wr_idx = i; wr_data = v;
        case (k)
            2'd0: ma[i] = v;
            2'd1: mo[i[1:0]] = v;
            2'd2: mm[i[2:0]] = v;
            default: ;
        endcase
        expect_read(k, i, tag);
        wr_en = 0;
    endtask

    task automatic do_op(input logic [3:0] op, input logic [3:0] d, input logic [1:0] sk,
                         input logic [3:0] si, input logic [31:0] imm, input string tag);
        @(negedge clk);
        op_valid = 1; op_code = op; op_dst = d; src_kind = sk; src_idx = si; op_imm = imm;
        model_op(op, d, model_src(sk, si, imm));
        expect_read(2'd0, d, tag);
        op_valid = 0;
    endtask

    // Monitor: compare each queued expectation with the read port and flag.
    initial begin
        forever begin
            @(posedge clk);
            #4;
            while (q_tag.size() > 0) begin
                string tg;
                logic [31:0] ev;
                logic et;
                tg = q_tag.pop_front();
                ev = q_val.pop_front();
                et = q_t.pop_front();
                checks++;
                if (rd_data !== ev) begin
                    errors++;
                    $display("FAIL %s: rd_data=%h expected %h", tg, rd_data, ev);
                end
                checks++;
                if (t_flag !== et) begin
                    errors++;
                    $display("FAIL %s: t_flag=%b expected %b", tg, t_flag, et);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) ma[i] = 0;
        for (int i = 0; i < 4; i++)  mo[i] = 0;
        for (int i = 0; i < 8; i++)  mm[i] = 32'hFFFF_FFFF;
        mt = 0;
        // Hold the block in reset while an operation is offered.
        op_valid = 1; op_code = 4'd9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        op_valid = 0;
        rst_n = 1;

        // R1: reset state of every register and the flag
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            expect_read(2'd0, 4'(i), "R1 address reset");
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            expect_read(2'd1, 4'(i), "R1 offset reset");
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            expect_read(2'd2, 4'(i), "R1 modifier reset");
        end

        // R2: write port and read-back of each kind
        do_write(2'd0, 4'd12, 32'h1234_5678, "R2 address write");
        do_write(2'd1, 4'd2,  32'h0000_0010, "R2 offset write");
        do_write(2'd2, 4'd6,  32'h0000_00FF, "R2 modifier write");
        do_write(2'd3, 4'd1,  32'hDEAD_BEEF, "R2 kind 3 reads zero");
        // R2: write port wins over an operation on the same register
        @(negedge clk);
        op_valid = 1; op_code = 4'd1; op_dst = 4'd12; src_kind = 2'd2; op_imm = 32'd5;
        wr_en = 1; wr_kind = 2'd0; wr_idx = 4'd12; wr_data = 32'hCAFE_0000;
        ma[12] = 32'hCAFE_0000;
        expect_read(2'd0, 4'd12, "R2 write priority");
        op_valid = 0; wr_en = 0;

        // R3: linear adds with each source type and shift
        do_write(2'd0, 4'd0, 32'd100, "R3 setup");
        do_op(4'd1, 4'd0, 2'd2, 4'd0, 32'd23, "R3 add immediate");
        do_op(4'd2, 4'd0, 2'd1, 4'd2, 32'd0, "R3 add offset shl1");
        do_write(2'd0, 4'd9, 32'h0000_0003, "R3 setup");
        do_op(4'd3, 4'd0, 2'd0, 4'd9, 32'd0, "R3 add register shl2");
        do_op(4'd1, 4'd0, 2'd2, 4'd0, 32'hFFFF_FFF0, "R3 add wraps 2^32");

        // R4: modulo 8 window, wrap at top and at zero
        do_write(2'd2, 4'd0, 32'h0000_0007, "R4 setup");
        do_write(2'd0, 4'd0, 32'h1000_0006, "R4 setup");
        do_op(4'd1, 4'd0, 2'd2, 4'd0, 32'd3, "R4 wrap past top");
        do_write(2'd0, 4'd0, 32'h1000_0000, "R4 setup");
        do_op(4'd4, 4'd0, 2'd2, 4'd0, 32'd0, "R4 decrement wraps at zero");
        // R4: modulus 2^31 keeps only the top bit
        do_write(2'd2, 4'd1, 32'h7FFF_FFFF, "R4 setup");
        do_write(2'd0, 4'd1, 32'h7FFF_FFFF, "R4 setup");
        do_op(4'd1, 4'd1, 2'd2, 4'd0, 32'd1, "R4 modulus 2^31 wrap");
        // R4: modulus 2 with add-shift2
        do_write(2'd2, 4'd2, 32'h0000_0001, "R4 setup");
        do_write(2'd0, 4'd2, 32'h0000_0005, "R4 setup");
        do_op(4'd3, 4'd2, 2'd2, 4'd0, 32'd1, "R4 modulus 2 shifted add");

        // R5: registers 8-15 stay linear
        do_write(2'd0, 4'd8, 32'h1000_0006, "R5 setup");
        do_op(4'd1, 4'd8, 2'd2, 4'd0, 32'd3, "R5 register 8 linear");
        do_write(2'd0, 4'd15, 32'h0000_0000, "R5 setup");
        do_op(4'd4, 4'd15, 2'd2, 4'd0, 32'd0, "R5 register 15 linear decrement");

        // R6: decrement-test flag and linear behaviour
        do_write(2'd0, 4'd10, 32'd1, "R6 setup");
        do_op(4'd5, 4'd10, 2'd2, 4'd0, 32'd0, "R6 dect reaches zero");
        do_op(4'd5, 4'd10, 2'd2, 4'd0, 32'd0, "R6 dect below zero");
        do_write(2'd0, 4'd0, 32'h1000_0000, "R6 setup");
        do_op(4'd5, 4'd0, 2'd2, 4'd0, 32'd0, "R6 dect ignores modifier");

        // R7: shifts ignore the modifier
        do_write(2'd2, 4'd3, 32'h0000_0007, "R7 setup");
        do_write(2'd0, 4'd3, 32'h8000_0001, "R7 setup");
        do_op(4'd8, 4'd3, 2'd2, 4'd0, 32'd0, "R7 arithmetic shift right");
        do_op(4'd6, 4'd3, 2'd2, 4'd0, 32'd0, "R7 shift left one");
        do_op(4'd7, 4'd3, 2'd2, 4'd0, 32'd0, "R7 shift left two");

        // R8: compares with the top bit set
        do_write(2'd0, 4'd4, 32'h8000_0000, "R8 setup");
        do_op(4'd10, 4'd4, 2'd2, 4'd0, 32'd1, "R8 signed gt negative");
        do_op(4'd11, 4'd4, 2'd2, 4'd0, 32'd1, "R8 unsigned higher");
        do_op(4'd9,  4'd4, 2'd2, 4'd0, 32'h8000_0000, "R8 equal");
        do_op(4'd9,  4'd4, 2'd2, 4'd0, 32'h8000_0001, "R8 not equal");
        do_op(4'd10, 4'd4, 2'd2, 4'd0, 32'hFFFF_FFFF, "R8 signed gt minus one");

        // R9: flag held across non-flag operations
        do_op(4'd9, 4'd4, 2'd2, 4'd0, 32'h8000_0000, "R9 set flag");
        do_op(4'd1, 4'd4, 2'd2, 4'd0, 32'd1, "R9 add keeps flag");
        do_op(4'd0, 4'd4, 2'd2, 4'd0, 32'd0, "R9 nop keeps flag");

        // R3 R4 R5 R6 R7 R8 R9: random mix against the model
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r == 0) begin
                int k;
                k = $urandom_range(1, 32);
                do_write(2'd2, 4'($urandom_range(0, 7)),
                         (k == 32) ? 32'hFFFF_FFFF : ((32'd1 << k) - 1), "R4 random modifier");
            end else if (r == 1) begin
                do_write(2'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
                         $urandom(), "R2 random write");
            end else begin
                do_op(4'($urandom_range(0, 11)), 4'($urandom_range(0, 15)),
                      2'($urandom_range(0, 2)), 4'($urandom_range(0, 15)),
                      $urandom(), "R3-R9 random op");
            end
        end

        @(posedge clk);
        #6;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule